// File: doc/BRIEF.md
# Synchronous FIFO with Clamped Threshold Flags

This block is a single-clock first-in first-out buffer meant for the transmit or receive path of a serial controller. Words enter through a push port and leave through a pop port. A fill-level counter tracks how many words are stored. A threshold value, loaded through a small configuration port, is compared against that level. The result drives two complementary flags that an interrupt controller can watch: one for "at or above threshold" and one for "below threshold". Empty and full flags are also provided.

Pushing into a full buffer and popping from an empty one are harmless. A push into a full buffer is discarded. A pop from an empty buffer loads zero into the read-data register and changes nothing else. A threshold write is forced into the range 1 to DEPTH-2, so the two threshold flags always have a meaningful crossing point. DEPTH must be at least 3. All flags are registered and always match the level and threshold shown on the ports.

Top module: `trig_fifo`

## Requirements
- R1: A push while level_o is below DEPTH stores push_data_i at the tail, and level_o rises by one at the next clock edge.
- R2: A push while level_o equals DEPTH, without a pop in the same cycle, is discarded: level_o stays at DEPTH and the stored words and their order are unchanged.
- R3: A pop while level_o is non-zero loads the oldest stored word into pop_data_o at the clock edge, and level_o falls by one. pop_data_o holds its value until the next pop.
- R4: A pop while level_o is zero loads 0 into pop_data_o and leaves level_o unchanged. If a push arrives in the same cycle, that word is still stored.
- R5: After a synchronous active-low reset, level_o is 0, trig_o is 1, pop_data_o is 0, empty_o and below_trig_o are 1, and full_o and at_trig_o are 0.
- R6: A configuration write of 0 sets trig_o to 1 from the next cycle.
- R7: A configuration write above DEPTH-2 sets trig_o to DEPTH-2. Any value from 1 to DEPTH-2 is stored unchanged. The new value appears on trig_o in the cycle after the write.
- R8: at_trig_o is 1 exactly when level_o >= trig_o, and below_trig_o is 1 exactly when level_o < trig_o. Both are compared against the level and threshold that are on the ports in the same cycle.
- R9: empty_o is 1 exactly when level_o is 0, and full_o is 1 exactly when level_o equals DEPTH.
- R10: A simultaneous push and pop with level_o between 1 and DEPTH-1 leaves level_o unchanged and returns the head word. With level_o at DEPTH, the pop is served, the push is discarded and level_o falls by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| push_i | input | 1 | Push request |
| push_data_i | input | DATA_W | Word to store |
| pop_i | input | 1 | Pop request |
| pop_data_o | output | DATA_W | Last popped word, or 0 after a pop on empty |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_trig_i | input | $clog2(DEPTH+1) | Requested threshold before clamping |
| level_o | output | $clog2(DEPTH+1) | Current fill level |
| trig_o | output | $clog2(DEPTH+1) | Clamped threshold in force |
| empty_o | output | 1 | Level is zero |
| full_o | output | 1 | Level equals DEPTH |
| at_trig_o | output | 1 | Level at or above threshold |
| below_trig_o | output | 1 | Level below threshold |

## Verification
A wrong pointer shows up on pop_data_o at the first pop that reaches the corrupted slot. That can be up to DEPTH pops after the fault, so the bench drains the buffer completely after each fill. A wrong level counter, a wrong clamp or a stale flag register shows up on the ports at the very next clock edge. Because of this, level_o, trig_o and all four flags are compared with the reference model on every cycle, including the cycles with full pushes, empty pops and out-of-range threshold writes.

// File: rtl/trig_fifo_pkg.sv
// Shared helpers for the threshold FIFO.
// Assumes callers pass the FIFO depth (at least 3) as an integer.
package trig_fifo_pkg;

    // Force a requested threshold into the legal window 1 .. depth-2.
    function automatic int clamp_trig(input int req, input int depth);
        int hi;
        hi = depth - 2;
        if (req < 1)
            return 1;
        else if (req > hi)
            return hi;
        else
            return req;
    endfunction

    // Advance a circular index, wrapping at depth (depth need not be a power of two).
    function automatic int wrap_inc(input int idx, input int depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/fifo_ram.sv
// Storage array for the FIFO: one write port, one asynchronous read port.
// Assumes the controller never writes and reads a slot in a conflicting way;
// read data for the head slot is sampled by the top-level output register.
module fifo_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Write the incoming word into the tail slot.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_ptr] <= wr_data;
    end

    // Present the head slot.
    assign rd_data = mem_q[rd_ptr];

endmodule

// File: rtl/fifo_ctrl.sv
// Pointer and level bookkeeping for the FIFO.
// Decides which requests are accepted, using the level before the edge:
// a push is accepted below DEPTH, a pop is accepted above zero.
module fifo_ctrl
    import trig_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    output logic             push_ok,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level_q,
    output logic [LVL_W-1:0] level_d
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

    // Accept requests against the level before the edge.
    always_comb begin
        push_ok = push_i && (level_q != LVL_MAX);
        pop_ok  = pop_i  && (level_q != '0);
    end

    // Next level from the accepted requests.
    always_comb begin
        unique case ({push_ok, pop_ok})
            2'b10:   level_d = level_q + 1'b1;
            2'b01:   level_d = level_q - 1'b1;
            default: level_d = level_q;
        endcase
    end

    // Register pointers and level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push_ok)
                wr_ptr_q <= PTR_W'(wrap_inc(int'(wr_ptr_q), DEPTH));
            if (pop_ok)
                rd_ptr_q <= PTR_W'(wrap_inc(int'(rd_ptr_q), DEPTH));
            level_q <= level_d;
        end
    end

    assign wr_ptr = wr_ptr_q;
    assign rd_ptr = rd_ptr_q;

endmodule

// File: rtl/trig_cfg.sv
// Threshold register with write-time clamping to 1 .. DEPTH-2.
// Assumes DEPTH >= 3. Exposes the next value so that flags can be registered in step.
module trig_cfg
    import trig_fifo_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [LVL_W-1:0] cfg_trig_i,
    output logic [LVL_W-1:0] trig_q,
    output logic [LVL_W-1:0] trig_d
);

    // Clamp the requested value when a write is present.
    always_comb begin
        trig_d = trig_q;
        if (cfg_we_i)
            trig_d = LVL_W'(clamp_trig(int'(cfg_trig_i), DEPTH));
    end

    // Hold the threshold; reset value is 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= LVL_W'(1);
        else
            trig_q <= trig_d;
    end

endmodule

// File: rtl/flag_gen.sv
// Registered status flags computed from the next level and next threshold,
// so that after each edge they agree with the registered level and threshold.
module flag_gen #(
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_d,
    input  logic [LVL_W-1:0] trig_d,
    output logic             empty_q,
    output logic             full_q,
    output logic             at_trig_q,
    output logic             below_trig_q
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    // Register the four flags from the next-state values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q      <= 1'b1;
            full_q       <= 1'b0;
            at_trig_q    <= 1'b0;
            below_trig_q <= 1'b1;
        end else begin
            empty_q      <= (level_d == '0);
            full_q       <= (level_d == LVL_MAX);
            at_trig_q    <= (level_d >= trig_d);
            below_trig_q <= (level_d <  trig_d);
        end
    end

endmodule

// File: rtl/trig_fifo.sv
// Top level of the threshold FIFO. Connects the storage, the controller,
// the threshold register and the flag generator, and owns the pop-data register.
// Assumes DEPTH >= 3 and a single clock domain.
module trig_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic              cfg_we_i,
    input  logic [LVL_W-1:0]  cfg_trig_i,
    output logic [LVL_W-1:0]  level_o,
    output logic [LVL_W-1:0]  trig_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              at_trig_o,
    output logic              below_trig_o
);

    logic              push_ok, pop_ok;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  level_q, level_d, trig_q, trig_d;
    logic [DATA_W-1:0] head_word;
    logic [DATA_W-1:0] pop_data_q;

    fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (push_i),
        .pop_i   (pop_i),
        .push_ok (push_ok),
        .pop_ok  (pop_ok),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .level_q (level_q),
        .level_d (level_d)
    );

    fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data_i),
        .rd_ptr  (rd_ptr),
        .rd_data (head_word)
    );

    trig_cfg #(.DEPTH(DEPTH)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we_i   (cfg_we_i),
        .cfg_trig_i (cfg_trig_i),
        .trig_q     (trig_q),
        .trig_d     (trig_d)
    );

    flag_gen #(.DEPTH(DEPTH)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .level_d      (level_d),
        .trig_d       (trig_d),
        .empty_q      (empty_o),
        .full_q       (full_o),
        .at_trig_q    (at_trig_o),
        .below_trig_q (below_trig_o)
    );

    // Capture the head word on an accepted pop, zero on a pop from empty.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pop_data_q <= '0;
        else if (pop_i)
            pop_data_q <= pop_ok ? head_word : '0;
    end

    assign pop_data_o = pop_data_q;
    assign level_o    = level_q;
    assign trig_o     = trig_q;

endmodule

// File: rtl/trig_fifo_chk.sv
// Port-level properties of the threshold FIFO, bound to every instance of the top.
module trig_fifo_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pop_i,
    input logic [DATA_W-1:0] pop_data_o,
    input logic              cfg_we_i,
    input logic [LVL_W-1:0]  cfg_trig_i,
    input logic [LVL_W-1:0]  level_o,
    input logic [LVL_W-1:0]  trig_o,
    input logic              empty_o,
    input logic              full_o,
    input logic              at_trig_o,
    input logic              below_trig_o
);

    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] TRIG_HI = LVL_W'(DEPTH - 2);

    // R1
    push_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (level_o == $past(level_o) + 1'b1));

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> (level_o == LVL_MAX));

    // R4
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && empty_o) |=> (pop_data_o == '0 && level_o == '0));

    // R6
    trig_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_trig_i == '0) |=> (trig_o == LVL_W'(1)));

    // R7
    trig_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o >= LVL_W'(1)) && (trig_o <= TRIG_HI));

    // R7
    trig_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_trig_i > TRIG_HI) |=> (trig_o == TRIG_HI));

    // R8
    at_trig_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        at_trig_o == (level_o >= trig_o));

    // R8
    flags_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({at_trig_o, below_trig_o}));

    // R9
    empty_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o == (level_o == '0)) && (full_o == (level_o == LVL_MAX)));

    // R10
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o && !full_o) |=> $stable(level_o));

endmodule

bind trig_fifo trig_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (push_i),
    .pop_i        (pop_i),
    .pop_data_o   (pop_data_o),
    .cfg_we_i     (cfg_we_i),
    .cfg_trig_i   (cfg_trig_i),
    .level_o      (level_o),
    .trig_o       (trig_o),
    .empty_o      (empty_o),
    .full_o       (full_o),
    .at_trig_o    (at_trig_o),
    .below_trig_o (below_trig_o)
);

// File: tb/trig_fifo_tb.sv
// Bench: behavioural queue model, stepped in lockstep with the design and compared every cycle.
module trig_fifo_tb;

    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int LVL_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_i = 1'b0;
    logic [DATA_W-1:0] push_data_i = '0;
    logic              pop_i = 1'b0;
    logic [DATA_W-1:0] pop_data_o;
    logic              cfg_we_i = 1'b0;
    logic [LVL_W-1:0]  cfg_trig_i = '0;
    logic [LVL_W-1:0]  level_o, trig_o;
    logic              empty_o, full_o, at_trig_o, below_trig_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_q[$];
    int m_trig = 1;
    int m_rd = 0;

    always #10 clk = ~clk;

    trig_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i),
        .pop_i(pop_i), .pop_data_o(pop_data_o),
        .cfg_we_i(cfg_we_i), .cfg_trig_i(cfg_trig_i),
        .level_o(level_o), .trig_o(trig_o),
        .empty_o(empty_o), .full_o(full_o),
        .at_trig_o(at_trig_o), .below_trig_o(below_trig_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int lvl;
        lvl = m_q.size();
        chk({tag, " level"}, int'(level_o), lvl);
        chk({tag, " data"}, int'(pop_data_o), m_rd);
        chk("R7 trig", int'(trig_o), m_trig);
        chk("R9 empty", int'(empty_o), int'(lvl == 0));
        chk("R9 full", int'(full_o), int'(lvl == DEPTH));
        chk("R8 at", int'(at_trig_o), int'(lvl >= m_trig));
        chk("R8 below", int'(below_trig_o), int'(lvl < m_trig));
    endtask

    // One cycle: drive after the falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(input bit ps, input int d, input bit pp, input bit we, input int tv, input string tag);
        push_i = ps; push_data_i = DATA_W'(d); pop_i = pp;
        cfg_we_i = we; cfg_trig_i = LVL_W'(tv);
        @(posedge clk);
        begin
            bit acc;
            acc = ps && (m_q.size() < DEPTH);
            if (pp) m_rd = (m_q.size() > 0) ? m_q.pop_front() : 0;
            if (acc) m_q.push_back(d);
            if (we) m_trig = (tv < 1) ? 1 : (tv > DEPTH - 2) ? DEPTH - 2 : tv;
        end
        @(negedge clk);
        push_i = 0; pop_i = 0; cfg_we_i = 0;
        compare_all(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R5 reset state
        chk("R5 level", int'(level_o), 0);
        chk("R5 trig", int'(trig_o), 1);
        chk("R5 data", int'(pop_data_o), 0);
        chk("R5 empty", int'(empty_o), 1);
        chk("R5 full", int'(full_o), 0);
        chk("R5 at", int'(at_trig_o), 0);
        chk("R5 below", int'(below_trig_o), 1);
        rst_n = 1'b1;

        // R4 pop on empty
        step(0, 0, 1, 0, 0, "R4");
        // R6 threshold floor, R7 ceiling and in-range values
        step(0, 0, 0, 1, 0, "R6");
        step(0, 0, 0, 1, 15, "R7");
        step(0, 0, 0, 1, 16, "R7");
        step(0, 0, 0, 1, 5, "R7");
        // R1 fill to full; R8 crossings along the way
        for (int i = 0; i < DEPTH; i++) step(1, 8'hA0 + i, 0, 0, 0, "R1");
        // R2 pushes into full are dropped
        step(1, 8'h55, 0, 0, 0, "R2");
        step(1, 8'h66, 0, 0, 0, "R2");
        // R10 push and pop while full: pop served, push dropped
        step(1, 8'h77, 1, 0, 0, "R10");
        // R3 drain in order
        for (int i = 0; i < DEPTH - 1; i++) step(0, 0, 1, 0, 0, "R3");
        // R4 pop on empty with a push in the same cycle
        step(1, 8'h3C, 1, 0, 0, "R4");
        // R10 simultaneous push and pop on a partly filled buffer
        step(1, 8'h11, 0, 0, 0, "R1");
        step(1, 8'h22, 1, 0, 0, "R10");
        step(1, 8'h33, 1, 1, 2, "R10");
        // Mixed traffic from an LFSR
        begin
            logic [15:0] lf;
            lf = 16'hACE1;
            for (int n = 0; n < 600; n++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                step(lf[0] | lf[3], int'(lf[15:8]), lf[1] & ~lf[5], lf[7:2] == 6'h11, int'(lf[12:8]), "R3");
            end
        end
        // Final drain
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, 0, "R3");
        // R5 reset mid-run
        step(1, 8'h9, 0, 1, 9, "R1");
        rst_n = 1'b0;
        @(posedge clk);
        m_q.delete(); m_trig = 1; m_rd = 0;
        @(negedge clk);
        compare_all("R5");
        rst_n = 1'b1;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule